// File: doc/BRIEF.md
# Four-Phase Non-Overlapping Clock Generator

This block turns one fast reference clock into four non-overlapping phase pulses of the kind used to sequence a four-phase dynamic memory. A synchronous modulo-12 counter runs from the reference clock. Four window decoders select chosen counter states, and each phase output comes from a flip-flop. At a 25 MHz reference each count lasts 40 ns and one full phase frame lasts 480 ns.

The default windows are as follows. The first phase spans counts 0 and 1 (80 ns). The second spans counts 3 and 4. The third spans counts 6 through 9, giving one long 160 ns pulse. The fourth is a single-count pulse in count 11. Counts 2, 5 and 10 are single-count gaps in which every phase is low. A one-clock frame marker flags each wrap of the counter. Translation to large negative clock swings and driver edge shaping belong to circuitry outside this block.

Top module: `quad_phase_clkgen`

## Requirements
- R1: While enabled, the counter advances by one per clock and wraps from 11 to 0. Frame markers on an uninterrupted run are therefore exactly 12 clocks apart.
- R2: Phase output bit 0 is high exactly when the counter holds 0 or 1.
- R3: Phase output bit 1 is high exactly when the counter holds 3 or 4.
- R4: Phase output bit 2 is high exactly when the counter holds 6, 7, 8 or 9.
- R5: Phase output bit 3 is high exactly when the counter holds 11.
- R6: At most one phase output is high in any clock cycle.
- R7: A synchronous reset sets the counter to 0 and drives all phases and the frame marker low in the cycle after the reset edge. After reset releases with enable high, the first enabled edge moves the counter to 1.
- R8: While enable is low, the counter holds its value and all phases and the frame marker are low. When enable returns, the sequence resumes from the held count plus one.
- R9: The frame marker is high for exactly one clock, in the cycle after an enabled edge that moved the counter from 11 to 0.
- R10: Every output is a flip-flop output. Each phase is registered from the decode of the counter's next value, so it lines up with the count it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low freezes the counter and blanks the phases |
| phase | output | 4 | Phase pulses, bit 0 = first phase |
| frame_start | output | 1 | One-clock marker after the counter wraps to 0 |

## Verification
The bench builds the block with its default parameters: a period of 12 counts and windows at 0–1, 3–4, 6–9 and 11. Under these values a single frame contains every window. This includes the long four-count pulse, the one-count pulse that lands just before the wrap, and all three single-count gaps, so about 12 clocks of stimulus reach each decode boundary. Enable drops are placed inside a pulse and inside a gap, and a reset arrives mid-frame. These cover freezing, resuming and restarting at points where a wrong hold value would shift the windows.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    localparam int unsigned NPH = 4;

    typedef logic [NPH-1:0] phase_vec_t;

    function automatic logic in_window(input int unsigned cnt,
                                       input int unsigned first,
                                       input int unsigned last);
        return (cnt >= first) && (cnt <= last);
    endfunction

endpackage

// File: rtl/qpc_counter.sv
module qpc_counter #(
    parameter int unsigned PERIOD = 12,
    localparam int unsigned CW = $clog2(PERIOD)
) (
    input  logic [CW-1:0] count_q,
    input  logic          en,
    output logic [CW-1:0] count_d,
    output logic          wrap
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    always_comb begin
        wrap    = en && (count_q == LAST);
        count_d = count_q;
        if (en) begin
            if (count_q == LAST) begin
                count_d = '0;
            end else begin
                count_d = count_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/qpc_window.sv
module qpc_window #(
    parameter int unsigned PERIOD = 12,
    parameter int unsigned FIRST  = 0,
    parameter int unsigned LAST   = 1,
    localparam int unsigned CW = $clog2(PERIOD)
) (
    input  logic [CW-1:0] count_next,
    output logic          hit
);

    always_comb begin
        hit = qpc_pkg::in_window(int'(count_next), FIRST, LAST);
    end

endmodule

// File: rtl/quad_phase_clkgen.sv
module quad_phase_clkgen
    import qpc_pkg::*;
#(
    parameter int unsigned PERIOD         = 12,
    parameter int unsigned PH_FIRST [NPH] = '{0, 3, 6, 11},
    parameter int unsigned PH_LAST  [NPH] = '{1, 4, 9, 11}
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    output logic [NPH-1:0] phase,
    output logic           frame_start
);

    localparam int unsigned CW = $clog2(PERIOD);

    typedef struct packed {
        logic [CW-1:0] count;
        phase_vec_t    ph;
        logic          start;
    } state_t;

    state_t state_d, state_q;

    logic [CW-1:0] cnt_next;
    logic          cnt_wrap;
    phase_vec_t    win_hit;

    qpc_counter #(.PERIOD(PERIOD)) i_counter (
        .count_q (state_q.count),
        .en      (en),
        .count_d (cnt_next),
        .wrap    (cnt_wrap)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_win
        qpc_window #(
            .PERIOD (PERIOD),
            .FIRST  (PH_FIRST[g]),
            .LAST   (PH_LAST[g])
        ) i_win (
            .count_next (cnt_next),
            .hit        (win_hit[g])
        );
    end

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d = '0;
        end else if (en) begin
            state_d.count = cnt_next;
            state_d.ph    = win_hit;
            state_d.start = cnt_wrap;
        end else begin
            state_d.ph    = '0;
            state_d.start = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign phase       = state_q.ph;
    assign frame_start = state_q.start;

    // Guards on the registered state
    assert_ph_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(state_q.ph));

    assert_count_range_R1: assert property (@(posedge clk) disable iff (rst)
        state_q.count < CW'(PERIOD));

    assert_count_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (en && state_q.count == CW'(PERIOD - 1)) |=> (state_q.count == '0));

    assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(state_q.count) && state_q.ph == '0 && !state_q.start));

    assert_reset_state_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q.count == '0 && state_q.ph == '0 && !state_q.start));

    assert_marker_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (state_q.count == '0));

    assert_marker_single_R9: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

endmodule

// File: tb/test_quad_phase_clkgen.sv
module test_quad_phase_clkgen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [3:0] phase;
    logic       frame_start;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    quad_phase_clkgen i_quad_phase_clkgen (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .phase       (phase),
        .frame_start (frame_start)
    );

    always #5 clk = ~clk;

    // Reference model
    int         ref_cnt   = 0;
    logic [3:0] ref_ph    = '0;
    logic       ref_start = 1'b0;
    int         gap       = 0;
    bit         clean     = 1'b0;

    function automatic logic [3:0] ref_windows(input int c);
        logic [3:0] m;
        m    = '0;
        m[0] = (c == 0 || c == 1);
        m[1] = (c == 3 || c == 4);
        m[2] = (c >= 6 && c <= 9);
        m[3] = (c == 11);
        return m;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ref_cnt = 0; ref_ph = '0; ref_start = 1'b0;
        end else if (en) begin
            ref_start = (ref_cnt == 11);
            ref_cnt   = (ref_cnt + 1) % 12;
            ref_ph    = ref_windows(ref_cnt);
        end else begin
            ref_ph = '0; ref_start = 1'b0;
        end
    end

    task automatic check_cycle(input bit in_rst, input bit in_off);
        checks++;
        if (phase !== ref_ph) begin
            errors++;
            if (in_rst)
                $display("FAIL R7 reset phases: got %b expected %b", phase, ref_ph);
            else if (in_off)
                $display("FAIL R8 disabled phases: got %b expected %b", phase, ref_ph);
            else if (phase[0] !== ref_ph[0])
                $display("FAIL R2 phase bit0 (count %0d): got %b expected %b", ref_cnt, phase, ref_ph);
            else if (phase[1] !== ref_ph[1])
                $display("FAIL R3 phase bit1 (count %0d): got %b expected %b", ref_cnt, phase, ref_ph);
            else if (phase[2] !== ref_ph[2])
                $display("FAIL R4 phase bit2 (count %0d): got %b expected %b", ref_cnt, phase, ref_ph);
            else
                $display("FAIL R5 phase bit3 (count %0d): got %b expected %b", ref_cnt, phase, ref_ph);
        end
        checks++;
        if (frame_start !== ref_start) begin
            errors++;
            $display("FAIL R9 frame marker (count %0d): got %b expected %b", ref_cnt, frame_start, ref_start);
        end
        checks++;
        if (!$onehot0(phase) || $isunknown(phase)) begin
            errors++;
            $display("FAIL R6 overlap: got %b expected at most one bit", phase);
        end
        // R1: marker spacing on uninterrupted runs; R10 alignment is covered by the per-count compare
        if (frame_start === 1'b1) begin
            if (clean) begin
                checks++;
                if (gap != 12) begin
                    errors++;
                    $display("FAIL R1 marker spacing: got %0d expected 12", gap);
                end
            end
            gap = 0; clean = 1'b1;
        end
    endtask

    task automatic run(input int n, input bit r, input bit e);
        for (int i = 0; i < n; i++) begin
            rst = r; en = e;
            @(negedge clk);
            if (r || !e) clean = 1'b0;
            gap++;
            check_cycle(r, !e);
        end
    endtask

    initial begin
        @(negedge clk);
        run(3, 1'b1, 1'b1);   // R7 reset with enable high
        run(40, 1'b0, 1'b1);  // R1..R5 several frames
        run(5, 1'b0, 1'b0);   // R8 freeze inside a frame
        run(30, 1'b0, 1'b1);  // R8 resume
        run(7, 1'b0, 1'b1);
        run(2, 1'b1, 1'b1);   // R7 reset mid-frame
        run(20, 1'b0, 1'b1);
        for (int k = 0; k < 12; k++) begin  // R8 drops at many counts
            run(k + 1, 1'b0, 1'b1);
            run(1, 1'b0, 1'b0);
        end
        run(30, 1'b0, 1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule